// File: doc/BRIEF.md
# Packet Handle Allocator and Transmit Scheduler

This block hands out packet buffers to a host processor as small numbered handles. The host never sees page addresses. It writes an allocation command that carries a byte count. One clock later, a result register holds either the lowest free handle or a failure flag. The block tracks which handles are in use and how many fixed-size pages each one holds. It grants a request only when a handle is free and enough pages remain.

Once a packet is ready, the host writes its handle into the handle register and issues a queue command. The handle joins an ordered transmit queue. While transmission is enabled, the head of the queue is offered to the MAC engine, one packet at a time. The MAC engine reports each packet as sent or failed. A sent packet is either freed at once, when auto-free is on, or placed in a completion queue for the host to collect. A failed packet always goes to the completion queue and stops all further transmission. Four interrupt status bits, each with its own mask bit, drive a single interrupt line.

Top module: `pbm_top`

## Requirements
- R1: After reset, the result register (address 2) reads 0x8000. The status (4), mask (6) and control (7) registers read 0. The queue-heads register (3) reads 0x8080. `irq` and `mac_valid` are low.
- R2: A write to address 0 with opcode 1 in bits [15:13] and a byte count in bits [10:0] is an allocation. On the next cycle, address 2 reads the lowest-numbered free handle in its low bits with bit 15 clear, and status bit 2 is set.
- R3: An allocation needs ceil(count/256) pages, and a count of 0 needs one page. The pool holds 16 pages. If no handle is free or too few pages remain, address 2 reads 0x8000, status bit 2 is still set, and no handle or page is taken.
- R4: Opcode 2 pushes the handle held at address 1 onto the transmit queue. `mac_valid` is high only while control bit 0 is set, the queue is not empty and no packet is in flight. `mac_pkt` is then the oldest queued handle. A cycle with `mac_valid` and `mac_ready` both high removes the handle from the queue and puts it in flight.
- R5: An enqueue issued while the transmit queue holds 4 handles is ignored, and status bit 3 is set.
- R6: When `mac_done` reports success (`mac_ok` high), the action depends on control bit 1. If it is set, the handle and its pages are freed. If it is clear, the handle is pushed onto the completion queue.
- R7: When `mac_done` reports failure, the handle is pushed onto the completion queue and control bit 0 is cleared. No further handle is offered until the host sets bit 0 again.
- R8: A successful completion that finds the transmit queue empty sets status bit 1.
- R9: Status bit 0 is high exactly while the completion queue is not empty. Address 3 shows the completion head in bits [14:8] with bit 15 as "empty", and the transmit head in bits [6:0] with bit 7 as "empty". A write to address 5 removes the completion head.
- R10: Opcode 3 frees the handle held at address 1 and returns its pages. Freeing a handle that is not in use changes nothing.
- R11: `irq` is the OR of status AND mask. Writing a 1 to status bits 1 to 3 (address 4) clears them, and bit 0 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Masked interrupt request |
| mac_valid | output | 1 | A queued handle is offered to the MAC |
| mac_pkt | output | 3 | Offered handle |
| mac_ready | input | 1 | MAC takes the offered handle |
| mac_done | input | 1 | MAC finished the in-flight packet |
| mac_ok | input | 1 | Outcome with `mac_done`: 1 sent, 0 failed |

## Verification
The bench tests page exhaustion: the pool runs out of pages while handles remain free. A design that checked only the handle bitmap would grant a handle it has no pages for. The bench also frees the same handle twice. A design that skipped the in-use test would return the pages twice and later grant memory that does not exist. Other directed cases are a failure with packets still queued, which must leave them stranded, and a push to a full queue, which must neither overwrite the head nor skip the overflow flag. A long random phase mixes allocations, frees, queue commands and MAC reports in the same cycle and compares every register against the reference model.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int NIST   = 4;

  typedef enum logic [2:0] {
    RA_CMD   = 3'd0,
    RA_PNUM  = 3'd1,
    RA_ARES  = 3'd2,
    RA_HEADS = 3'd3,
    RA_IST   = 3'd4,
    RA_CACK  = 3'd5,
    RA_MASK  = 3'd6,
    RA_CTRL  = 3'd7
  } reg_addr_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ALLOC = 3'd1,
    OP_ENQ   = 3'd2,
    OP_FREE  = 3'd3
  } op_e;

  localparam int IST_CMPL  = 0;
  localparam int IST_EMPTY = 1;
  localparam int IST_ALLOC = 2;
  localparam int IST_OVF   = 3;
endpackage

// File: rtl/pbm_fifo.sv
module pbm_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/pbm_alloc.sv
module pbm_alloc #(
  parameter int NUM_PKTS   = 8,
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_BYTES = 256,
  parameter int NB_W       = 11,
  localparam int PW        = $clog2(NUM_PKTS),
  localparam int PGW       = $clog2(NUM_PAGES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  input  logic [NB_W-1:0] alloc_bytes,
  input  logic            rel_a_req,
  input  logic [PW-1:0]   rel_a_num,
  input  logic            rel_b_req,
  input  logic [PW-1:0]   rel_b_num,
  output logic            grant_ok,
  output logic [PW-1:0]   grant_num,
  output logic [PGW-1:0]  free_pages
);
  localparam int PSH    = $clog2(PAGE_BYTES);
  localparam int NEED_W = NB_W + 1 - PSH;
  localparam int SW     = ((PGW > NEED_W) ? PGW : NEED_W) + 2;

  logic [NUM_PKTS-1:0] used_q, used_d;
  logic [PGW-1:0]      pc_q [NUM_PKTS];
  logic [PGW-1:0]      pc_d [NUM_PKTS];
  logic [PGW-1:0]      free_q, free_d;
  logic [NB_W:0]       rounded;
  logic [NEED_W-1:0]   need;
  logic                found, fits, rel_a_ok, rel_b_ok;
  logic [PW-1:0]       low_idx;
  logic [SW-1:0]       pool_sum;

  assign rounded = {1'b0, alloc_bytes} + (NB_W + 1)'(PAGE_BYTES - 1);
  assign need    = (alloc_bytes == '0) ? NEED_W'(1) : NEED_W'(rounded >> PSH);

  always_comb begin
    found   = 1'b0;
    low_idx = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        found   = 1'b1;
        low_idx = PW'(i);
      end
    end
  end

  assign fits      = SW'(need) <= SW'(free_q);
  assign grant_ok  = alloc_req && found && fits;
  assign grant_num = low_idx;
  assign free_pages = free_q;

  assign rel_a_ok = rel_a_req && used_q[rel_a_num];
  assign rel_b_ok = rel_b_req && used_q[rel_b_num] && !(rel_a_ok && (rel_a_num == rel_b_num));

  always_comb begin
    used_d = used_q;
    for (int i = 0; i < NUM_PKTS; i++) pc_d[i] = pc_q[i];
    pool_sum = SW'(free_q);
    if (rel_a_ok) begin
      used_d[rel_a_num] = 1'b0;
      pool_sum = pool_sum + SW'(pc_q[rel_a_num]);
    end
    if (rel_b_ok) begin
      used_d[rel_b_num] = 1'b0;
      pool_sum = pool_sum + SW'(pc_q[rel_b_num]);
    end
    if (grant_ok) begin
      used_d[low_idx] = 1'b1;
      pc_d[low_idx]   = PGW'(need);
      pool_sum        = pool_sum - SW'(need);
    end
    free_d = PGW'(pool_sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      free_q <= PGW'(NUM_PAGES);
      for (int i = 0; i < NUM_PKTS; i++) pc_q[i] <= '0;
    end else begin
      used_q <= used_d;
      free_q <= free_d;
      for (int i = 0; i < NUM_PKTS; i++) pc_q[i] <= pc_d[i];
    end
  end
endmodule

// File: rtl/pbm_irq.sv
module pbm_irq #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_src,
  input  logic [NBITS-1:0] set_vec,
  input  logic [NBITS-1:0] clr_vec,
  input  logic [NBITS-1:0] mask,
  output logic [NBITS-1:0] status,
  output logic             irq
);
  genvar g;
  generate
    for (g = 0; g < NBITS; g++) begin : g_bit
      if (g == 0) begin : g_level
        assign status[g] = level_src;
      end else begin : g_sticky
        logic bit_q, bit_d;
        always_comb begin
          bit_d = bit_q;
          if (clr_vec[g]) bit_d = 1'b0;
          if (set_vec[g]) bit_d = 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) bit_q <= 1'b0;
          else        bit_q <= bit_d;
        end
        assign status[g] = bit_q;
      end
    end
  endgenerate

  assign irq = |(status & mask);
endmodule

// File: rtl/pbm_txseq.sv
module pbm_txseq #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic          auto_free,
  input  logic          q_empty,
  input  logic [PW-1:0] q_head,
  input  logic          mac_ready,
  input  logic          mac_done,
  input  logic          mac_ok,
  output logic          mac_valid,
  output logic [PW-1:0] mac_pkt,
  output logic          q_pop,
  output logic          busy,
  output logic          cmpl_push,
  output logic [PW-1:0] fin_num,
  output logic          free_req,
  output logic          fail_evt,
  output logic          drain_evt
);
  logic          busy_q, busy_d;
  logic [PW-1:0] cur_q, cur_d;
  logic          fin;

  assign mac_valid = tx_enable && !q_empty && !busy_q;
  assign mac_pkt   = q_head;
  assign q_pop     = mac_valid && mac_ready;
  assign busy      = busy_q;
  assign fin       = mac_done && busy_q;
  assign fin_num   = cur_q;
  assign free_req  = fin && mac_ok && auto_free;
  assign cmpl_push = fin && !(mac_ok && auto_free);
  assign fail_evt  = fin && !mac_ok;
  assign drain_evt = fin && mac_ok && q_empty;

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    if (fin) busy_d = 1'b0;
    if (q_pop) begin
      busy_d = 1'b1;
      cur_d  = q_head;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/pbm_top.sv
module pbm_top
  import pbm_pkg::*;
#(
  parameter int NUM_PKTS   = 8,
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_BYTES = 256,
  parameter int TXQ_DEPTH  = 4,
  parameter int NB_W       = 11,
  localparam int PW        = $clog2(NUM_PKTS),
  localparam int PGW       = $clog2(NUM_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              mac_valid,
  output logic [PW-1:0]     mac_pkt,
  input  logic              mac_ready,
  input  logic              mac_done,
  input  logic              mac_ok
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  reg_addr_e ra;
  op_e       op;
  logic      wr_cmd, cmd_alloc, cmd_enq, cmd_free;

  assign ra        = reg_addr_e'(reg_addr);
  assign op        = op_e'(reg_wdata[15:13]);
  assign wr_cmd    = reg_wr && (ra == RA_CMD);
  assign cmd_alloc = wr_cmd && (op == OP_ALLOC);
  assign cmd_enq   = wr_cmd && (op == OP_ENQ);
  assign cmd_free  = wr_cmd && (op == OP_FREE);

  logic [PW-1:0]   pnum_q, pnum_d;
  logic            ares_fail_q, ares_fail_d;
  logic [PW-1:0]   ares_num_q, ares_num_d;
  logic [NIST-1:0] mask_q, mask_d;
  logic            txena_q, txena_d;
  logic            afree_q, afree_d;

  logic            grant_ok;
  logic [PW-1:0]   grant_num;
  logic [PGW-1:0]  free_pages;
  logic            txq_empty, txq_full, cq_empty, cq_full;
  logic [PW-1:0]   txq_head, cq_head;
  logic            q_pop, busy, cmpl_push, free_req, fail_evt, drain_evt;
  logic [PW-1:0]   fin_num;
  logic [NIST-1:0] ist, ist_set, ist_clr;

  pbm_alloc #(
    .NUM_PKTS(NUM_PKTS), .NUM_PAGES(NUM_PAGES),
    .PAGE_BYTES(PAGE_BYTES), .NB_W(NB_W)
  ) u_alloc (
    .clk(clk), .rst_n(rst_n_s),
    .alloc_req(cmd_alloc), .alloc_bytes(reg_wdata[NB_W-1:0]),
    .rel_a_req(cmd_free), .rel_a_num(pnum_q),
    .rel_b_req(free_req), .rel_b_num(fin_num),
    .grant_ok(grant_ok), .grant_num(grant_num), .free_pages(free_pages)
  );

  pbm_fifo #(.W(PW), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_s), .push(cmd_enq), .pop(q_pop),
    .din(pnum_q), .head(txq_head), .empty(txq_empty), .full(txq_full)
  );

  pbm_fifo #(.W(PW), .DEPTH(NUM_PKTS)) u_cq (
    .clk(clk), .rst_n(rst_n_s), .push(cmpl_push),
    .pop(reg_wr && (ra == RA_CACK)),
    .din(fin_num), .head(cq_head), .empty(cq_empty), .full(cq_full)
  );

  pbm_txseq #(.PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .tx_enable(txena_q), .auto_free(afree_q),
    .q_empty(txq_empty), .q_head(txq_head),
    .mac_ready(mac_ready), .mac_done(mac_done), .mac_ok(mac_ok),
    .mac_valid(mac_valid), .mac_pkt(mac_pkt), .q_pop(q_pop), .busy(busy),
    .cmpl_push(cmpl_push), .fin_num(fin_num), .free_req(free_req),
    .fail_evt(fail_evt), .drain_evt(drain_evt)
  );

  always_comb begin
    ist_set            = '0;
    ist_set[IST_EMPTY] = drain_evt;
    ist_set[IST_ALLOC] = cmd_alloc;
    ist_set[IST_OVF]   = cmd_enq && txq_full;
    ist_clr            = '0;
    if (reg_wr && (ra == RA_IST)) ist_clr = reg_wdata[NIST-1:0];
  end

  pbm_irq #(.NBITS(NIST)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .level_src(!cq_empty),
    .set_vec(ist_set), .clr_vec(ist_clr), .mask(mask_q),
    .status(ist), .irq(irq)
  );

  always_comb begin
    pnum_d      = pnum_q;
    ares_fail_d = ares_fail_q;
    ares_num_d  = ares_num_q;
    mask_d      = mask_q;
    txena_d     = txena_q;
    afree_d     = afree_q;
    if (reg_wr && (ra == RA_PNUM)) pnum_d = reg_wdata[PW-1:0];
    if (reg_wr && (ra == RA_MASK)) mask_d = reg_wdata[NIST-1:0];
    if (reg_wr && (ra == RA_CTRL)) begin
      txena_d = reg_wdata[0];
      afree_d = reg_wdata[1];
    end
    if (cmd_alloc) begin
      ares_fail_d = !grant_ok;
      ares_num_d  = grant_ok ? grant_num : '0;
    end
    if (fail_evt) txena_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pnum_q      <= '0;
      ares_fail_q <= 1'b1;
      ares_num_q  <= '0;
      mask_q      <= '0;
      txena_q     <= 1'b0;
      afree_q     <= 1'b0;
    end else begin
      pnum_q      <= pnum_d;
      ares_fail_q <= ares_fail_d;
      ares_num_q  <= ares_num_d;
      mask_q      <= mask_d;
      txena_q     <= txena_d;
      afree_q     <= afree_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (ra)
      RA_PNUM:  reg_rdata[PW-1:0] = pnum_q;
      RA_ARES:  begin
        reg_rdata[15]     = ares_fail_q;
        reg_rdata[PW-1:0] = ares_num_q;
      end
      RA_HEADS: begin
        reg_rdata[15]       = cq_empty;
        reg_rdata[8+:PW]    = cq_head;
        reg_rdata[7]        = txq_empty;
        reg_rdata[PW-1:0]   = txq_head;
      end
      RA_IST:   reg_rdata[NIST-1:0] = ist;
      RA_MASK:  reg_rdata[NIST-1:0] = mask_q;
      RA_CTRL:  reg_rdata[1:0] = {afree_q, txena_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbm_sva.sv
module pbm_sva #(
  parameter int NUM_PAGES = 16,
  parameter int PW        = 3,
  parameter int PGW       = 5
) (
  input logic           clk,
  input logic           rst_n_s,
  input logic           cmd_alloc,
  input logic           cmd_enq,
  input logic           txq_full,
  input logic           txq_empty,
  input logic           txena_q,
  input logic           busy,
  input logic           mac_valid,
  input logic           mac_ready,
  input logic           mac_done,
  input logic           mac_ok,
  input logic [3:0]     ist,
  input logic [PGW-1:0] free_pages
);
  assert_alloc_flag_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_alloc |=> ist[2]);

  assert_pool_bound_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    free_pages <= NUM_PAGES);

  assert_offer_gated_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    mac_valid |-> txena_q);

  assert_single_flight_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mac_valid && mac_ready) |=> !mac_valid);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_enq && txq_full) |=> ist[3]);

  assert_fail_halts_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mac_done && busy && !mac_ok) |=> !txena_q);

  assert_drain_flag_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mac_done && busy && mac_ok && txq_empty) |=> ist[1]);
endmodule

bind pbm_top pbm_sva #(.NUM_PAGES(NUM_PAGES), .PW(PW), .PGW(PGW)) u_sva (
  .clk(clk), .rst_n_s(rst_n_s), .cmd_alloc(cmd_alloc), .cmd_enq(cmd_enq),
  .txq_full(txq_full), .txq_empty(txq_empty), .txena_q(txena_q), .busy(busy),
  .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_done(mac_done),
  .mac_ok(mac_ok), .ist(ist), .free_pages(free_pages)
);

// File: tb/pbm_top_tb.sv
`timescale 1ns/1ps
module pbm_top_tb;
  localparam int NPK = 8, NPG = 16, QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, mac_valid;
  logic [2:0]  mac_pkt;
  logic        mac_ready = 1'b0, mac_done = 1'b0, mac_ok = 1'b0;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pbm_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mac_valid(mac_valid), .mac_pkt(mac_pkt), .mac_ready(mac_ready),
    .mac_done(mac_done), .mac_ok(mac_ok)
  );

  // reference model state
  bit m_used [NPK];
  int m_pc   [NPK];
  int m_free, m_pnum, m_ares, m_mask, m_cur;
  bit m_txena, m_afree, m_busy, m_s1, m_s2, m_s3;
  int m_txq[$];
  int m_cq[$];

  function automatic void model_reset();
    for (int i = 0; i < NPK; i++) begin m_used[i] = 0; m_pc[i] = 0; end
    m_free = NPG; m_pnum = 0; m_ares = 16'h8000; m_mask = 0; m_cur = 0;
    m_txena = 0; m_afree = 0; m_busy = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    m_txq.delete(); m_cq.delete();
  endfunction

  function automatic bit m_valid();
    return m_txena && m_txq.size() != 0 && !m_busy;
  endfunction

  function automatic int m_ist();
    return (m_cq.size() != 0 ? 1 : 0) | (int'(m_s1) << 1) | (int'(m_s2) << 2) | (int'(m_s3) << 3);
  endfunction

  function automatic int m_read(int a);
    case (a)
      1: return m_pnum;
      2: return m_ares;
      3: return ((m_cq.size() == 0) ? 16'h8000 : (m_cq[0] << 8)) |
                ((m_txq.size() == 0) ? 16'h0080 : m_txq[0]);
      4: return m_ist();
      6: return m_mask;
      7: return (int'(m_afree) << 1) | int'(m_txena);
      default: return 0;
    endcase
  endfunction

  function automatic void model_clock(bit wr, int a, int d, bit rdy, bit dn, bit ok);
    int  op, bytes, need, low, pnum_pre;
    bit  take, fin, enq, enq_ok, rel_ok, ar_ok, cq_pop, cq_push, drain;
    int  take_num, fin_num;
    op = (d >> 13) & 7; bytes = d & 16'h07FF;
    pnum_pre = m_pnum;
    take = rdy && m_valid();
    take_num = take ? m_txq[0] : 0;
    fin = dn && m_busy;
    fin_num = m_cur;
    enq = wr && a == 0 && op == 2;
    enq_ok = enq && m_txq.size() < QD;
    rel_ok = wr && a == 0 && op == 3 && m_used[pnum_pre];
    ar_ok = fin && ok && m_afree && m_used[fin_num] && !(rel_ok && pnum_pre == fin_num);
    cq_pop = wr && a == 5 && m_cq.size() != 0;
    cq_push = fin && !(ok && m_afree) && m_cq.size() < NPK;
    drain = fin && ok && m_txq.size() == 0;
    // allocation against pre-state
    if (wr && a == 0 && op == 1) begin
      need = (bytes == 0) ? 1 : (bytes + 255) / 256;
      low = -1;
      for (int i = NPK - 1; i >= 0; i--) if (!m_used[i]) low = i;
      if (low >= 0 && need <= m_free) begin
        m_used[low] = 1; m_pc[low] = need; m_free -= need; m_ares = low;
      end else m_ares = 16'h8000;
    end
    if (rel_ok) begin m_used[pnum_pre] = 0; m_free += m_pc[pnum_pre]; end
    if (ar_ok)  begin m_used[fin_num] = 0;  m_free += m_pc[fin_num];  end
    if (take) void'(m_txq.pop_front());
    if (enq_ok) m_txq.push_back(pnum_pre);
    if (cq_pop) void'(m_cq.pop_front());
    if (cq_push) m_cq.push_back(fin_num);
    if (fin) m_busy = 0;
    if (take) begin m_busy = 1; m_cur = take_num; end
    if (wr && a == 4) begin
      if (d[1]) m_s1 = 0;
      if (d[2]) m_s2 = 0;
      if (d[3]) m_s3 = 0;
    end
    if (drain) m_s1 = 1;
    if (wr && a == 0 && op == 1) m_s2 = 1;
    if (enq && !enq_ok) m_s3 = 1;
    if (wr && a == 1) m_pnum = d & 7;
    if (wr && a == 6) m_mask = d & 15;
    if (wr && a == 7) begin m_txena = d[0]; m_afree = d[1]; end
    if (fin && !ok) m_txena = 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // compare all visible state; called at the falling edge
  task automatic compare();
    int exp_irq;
    reg_wr = 0;
    exp_irq = ((m_ist() & m_mask) != 0) ? 1 : 0;
    check(irq == exp_irq, "R11 irq", irq, exp_irq);
    check(mac_valid == m_valid(), "R4 mac_valid", mac_valid, m_valid());
    if (m_valid()) check(mac_pkt == m_txq[0], "R4 mac_pkt", mac_pkt, m_txq[0]);
    foreach (addrs_c[k]) begin
      reg_addr = 3'(addrs_c[k]);
      #1;
      check(reg_rdata == 16'(m_read(addrs_c[k])), tags_c[k], reg_rdata, m_read(addrs_c[k]));
    end
  endtask

  int    addrs_c[6] = '{1, 2, 3, 4, 6, 7};
  string tags_c[6]  = '{"R4 pnum", "R2 ares", "R9 heads", "R11 status", "R11 mask", "R7 ctrl"};

  task automatic step(input bit wr, input int a, input int d, input bit rdy, input bit dn, input bit ok);
    reg_wr = wr; reg_addr = 3'(a); reg_wdata = 16'(d);
    mac_ready = rdy; mac_done = dn; mac_ok = ok;
    @(posedge clk);
    model_clock(wr, a, d, rdy, dn, ok);
    @(negedge clk);
    mac_ready = 0; mac_done = 0; mac_ok = 0;
    compare();
  endtask

  task automatic wreg(input int a, input int d); step(1, a, d, 0, 0, 0); endtask
  task automatic alloc(input int n); wreg(0, (1 << 13) | n); endtask
  task automatic enq(input int p); wreg(1, p); wreg(0, 2 << 13); endtask
  task automatic rel(input int p); wreg(1, p); wreg(0, 3 << 13); endtask

  task automatic expect_reg(input int a, input int v, input string req);
    reg_wr = 0; reg_addr = 3'(a); #1;
    check(reg_rdata == 16'(v), req, reg_rdata, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    expect_reg(2, 16'h8000, "R1 ares");
    expect_reg(4, 0, "R1 status");
    expect_reg(6, 0, "R1 mask");
    expect_reg(7, 0, "R1 ctrl");
    expect_reg(3, 16'h8080, "R1 heads");
    check(irq == 0 && mac_valid == 0, "R1 outputs", {irq, mac_valid}, 0);
    compare();

    wreg(6, 15);
    alloc(100);  expect_reg(2, 0, "R2 first grant");
    alloc(600);  expect_reg(2, 1, "R2 three pages");
    alloc(0);    expect_reg(2, 2, "R3 zero count takes a page");
    alloc(2047); expect_reg(2, 3, "R2 eight pages");
    alloc(1024); expect_reg(2, 16'h8000, "R3 too few pages");
    alloc(768);  expect_reg(2, 4, "R3 exact fit");
    alloc(1);    expect_reg(2, 16'h8000, "R3 pool exhausted");
    rel(1); rel(1);
    alloc(513);  expect_reg(2, 1, "R10 freed handle reused");
    alloc(1);    expect_reg(2, 16'h8000, "R10 double free returned nothing");
    wreg(4, 4);  expect_reg(4, 0, "R11 w1c alloc bit");

    enq(0); enq(2); enq(3);
    check(mac_valid == 0, "R4 held while disabled", mac_valid, 0);
    wreg(7, 1);
    check(mac_valid == 1 && mac_pkt == 0, "R4 offer head", mac_pkt, 0);
    step(0, 0, 0, 1, 0, 0);
    check(mac_valid == 0, "R4 one in flight", mac_valid, 0);
    step(0, 0, 0, 0, 1, 1);
    expect_reg(4, 1, "R6 completion queued");
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 1);
    expect_reg(4, 3, "R8 drained flag");
    wreg(5, 0);
    expect_reg(3, 16'h0280, "R9 head after pop");

    wreg(7, 3);
    enq(4); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 1);
    alloc(700);  expect_reg(2, 4, "R6 auto freed handle regranted");

    enq(1); enq(4);
    step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0);
    expect_reg(7, 2, "R7 enable cleared");
    check(mac_valid == 0, "R7 queue stalled", mac_valid, 0);
    expect_reg(3, 16'h0204, "R7 stranded head");

    enq(5); enq(6); enq(7);
    wreg(4, 8);
    enq(0);
    expect_reg(4, 9 | 4 | 2, "R5 overflow flag");
    expect_reg(3, 16'h0204, "R5 head kept");
    wreg(6, 8); check(irq == 1, "R11 masked irq", irq, 1);
    wreg(4, 8); check(irq == 0, "R11 irq cleared", irq, 0);

    // random mixed traffic against the model
    for (int it = 0; it < 3000; it++) begin
      int a, d, sel;
      bit wr, rdy, dn;
      sel = $urandom_range(0, 9);
      wr = sel < 6;
      a = $urandom_range(0, 7);
      if ($urandom_range(0, 2) == 0) a = 0;
      d = $urandom_range(0, 16'hFFFF);
      if (a == 0) d = ($urandom_range(0, 4) << 13) | $urandom_range(0, 2047);
      if (a == 7 && $urandom_range(0, 3) != 0) d = d | 1;
      rdy = $urandom_range(0, 1);
      dn  = m_busy && ($urandom_range(0, 2) == 0);
      step(wr, a, d, rdy, dn, $urandom_range(0, 4) != 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule